// File: doc/BRIEF.md
# Strobed Serial Voice Port

This block is the serial edge of a voice transcoder. It carries two channels, each framed by its own 8 kHz strobe that stays high for exactly eight bit periods. The first channel moves one 8-bit companded sample per frame, in each direction. The second channel moves one compressed code per frame. That code is 4, 3 or 2 bits long, depending on the selected rate, and it sits inside the same eight-period window. Input bits are taken on the falling bit-clock edge, and output bits are launched on the rising edge. Each serial output has its own enable pin, which is high only while that channel's window is open.

In serial mode the bit clock comes from a pin and may run at any rate from 128 kHz to 4096 kHz. In bus mode that pin is ignored. An internal divider of the system clock then makes the bit clock, at nominally 2048 kbit/s, and drives it out on a pin so that the strobes can be aligned to it. The transcoder core sits behind the parallel side. It takes one frame, so a sample reaches the serial output two frames after it arrived.

On the parallel side, each received word is offered as a one-cycle `valid` pulse with no `ready`. A serial line cannot stall, so the core must take the word in that cycle. Each transmit word goes in through a valid/ready handshake into a one-word holding register. `ready` stays low while that register is full. The held word is consumed when the next window opens.

Top module: `sp_port`

## Requirements
- R1: Sample words are received MSB first, one bit per falling bit-clock edge inside the strobe window. After the eighth bit, `pcm_rx_valid_o` pulses for one cycle and `pcm_rx_data_o` holds the word.
- R2: The transmitted sample word is sent MSB first. Its bit 7 is launched on the rising edge that opens the window, and each following rising edge inside the window launches the next bit.
- R3: Each output enable is high exactly while its channel's window is open, from the opening rising edge to the first rising edge that sees the strobe low. A serial output is 0 whenever its enable is low.
- R4: `rate_i` selects the code length: 0 gives 4 bits, 1 gives 3 bits, 2 gives 2 bits, and 3 acts as 0. The code is sent and received MSB first from slot 0. Slots outside the code drive 0 and their input bits are ignored. Received codes are right-aligned in `adp_rx_data_o` with the upper bits 0. Transmit codes are taken from the low bits of the transmit word.
- R5: At the 2-bit rate, `slot_sel_i` = 0 places the code in slots 0 to 1 and `slot_sel_i` = 1 places it in slots 2 to 3. At any other rate, `slot_sel_i` has no effect.
- R6: A window that closes after fewer than eight falling edges raises that channel's error output for one cycle at the close. A word whose last bit was not received yields no valid pulse.
- R7: A transmit word is accepted when `valid` and `ready` are both high, after which `ready` is low until the next window opens and consumes the word. If no word is held when a window opens, that window sends zeros.
- R8: In bus mode, `bclk_i` has no effect. The bit clock on `bus_bclk_o` has a period of 2·BUS_HALF system clocks, and the strobe and data timing relative to it is the same as in serial mode.
- R9: After reset, both enables and serial outputs are 0, both `ready` outputs are 1, and no valid or error pulse is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_mode_i | input | 1 | 1 = internal bit clock, 0 = `bclk_i` |
| bclk_i | input | 1 | External bit clock (serial mode) |
| bus_bclk_o | output | 1 | Internal bit clock |
| pcm_stb_i | input | 1 | Sample channel strobe |
| adp_stb_i | input | 1 | Code channel strobe |
| rate_i | input | 2 | Code rate: 0=4 bit, 1=3 bit, 2=2 bit |
| slot_sel_i | input | 1 | Code position at the 2-bit rate |
| pcm_sdi_i | input | 1 | Sample serial input |
| pcm_sdo_o | output | 1 | Sample serial output |
| pcm_oe_o | output | 1 | Sample output enable |
| adp_sdi_i | input | 1 | Code serial input |
| adp_sdo_o | output | 1 | Code serial output |
| adp_oe_o | output | 1 | Code output enable |
| pcm_rx_data_o | output | 8 | Received sample word |
| pcm_rx_valid_o | output | 1 | Received sample pulse |
| adp_rx_data_o | output | 4 | Received code, right-aligned |
| adp_rx_valid_o | output | 1 | Received code pulse |
| pcm_tx_data_i | input | 8 | Sample word to send |
| pcm_tx_valid_i | input | 1 | Sample word offered |
| pcm_tx_ready_o | output | 1 | Sample holding register empty |
| adp_tx_data_i | input | 4 | Code to send (low bits) |
| adp_tx_valid_i | input | 1 | Code offered |
| adp_tx_ready_o | output | 1 | Code holding register empty |
| pcm_err_o | output | 1 | Short sample window pulse |
| adp_err_o | output | 1 | Short code window pulse |

## Verification
A slot counter that is off by one shows up within one window. The serial output pattern shifts by a bit, the enable drops a period early or late, and the valid pulse lands on the wrong edge. A code length or position latched wrongly shows in the same window, as received codes that contain ignored slot bits or as transmitted codes that are misplaced or truncated. A holding register that is flagged wrongly shows up one window later, either as a stuck `ready` or as a window of zeros where a word was expected. Random rates, positions, payloads and idle frames are mixed with short strobes and bus-mode frames to expose each of these.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [1:0] {
    RATE_4B  = 2'd0,
    RATE_3B  = 2'd1,
    RATE_2B  = 2'd2,
    RATE_RSV = 2'd3
  } adp_rate_e;

  // code length in bit slots for a rate setting
  function automatic logic [3:0] code_len(adp_rate_e r);
    case (r)
      RATE_3B: code_len = 4'd3;
      RATE_2B: code_len = 4'd2;
      default: code_len = 4'd4;
    endcase
  endfunction

  // first slot of the code; the position select acts only at the 2-bit rate
  function automatic logic [2:0] code_first(adp_rate_e r, logic sel);
    code_first = (r == RATE_2B && sel) ? 3'd2 : 3'd0;
  endfunction
endpackage

// File: rtl/sp_tick.sv
module sp_tick #(
  parameter int BUS_HALF = 12,
  parameter int NSIG     = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_mode_i,
  input  logic            bclk_i,
  input  logic [NSIG-1:0] sig_i,
  output logic            bus_bclk_o,
  output logic [NSIG-1:0] sig_o,
  output logic            rise_o,
  output logic            fall_o
);
  localparam int CW = (BUS_HALF > 1) ? $clog2(BUS_HALF) : 1;

  logic [CW-1:0] div_q;
  logic          ph_q;
  logic [NSIG:0] s1_q, s2_q;
  logic          prev_q;
  logic          src;

  // internal bit clock: half period of BUS_HALF system clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      ph_q  <= 1'b0;
    end else if (div_q == CW'(BUS_HALF - 1)) begin
      div_q <= '0;
      ph_q  <= ~ph_q;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign src = bus_mode_i ? ph_q : bclk_i;

  // clock source, strobes and data share one two-stage path to stay aligned
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= {sig_i, src};
      s2_q   <= s1_q;
      prev_q <= s2_q[0];
    end
  end

  assign rise_o     = s2_q[0] & ~prev_q;
  assign fall_o     = ~s2_q[0] & prev_q;
  assign sig_o      = s2_q[NSIG:1];
  assign bus_bclk_o = ph_q;

  p_bus_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_bclk_o) |=> bus_bclk_o);
  p_edge_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !fall_o);
endmodule

// File: rtl/sp_lane.sv
module sp_lane #(
  parameter int W     = 8,
  parameter int SLOTS = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rise_i,
  input  logic                       fall_i,
  input  logic                       stb_i,
  input  logic                       sdi_i,
  input  logic [$clog2(SLOTS)-1:0]   first_i,
  input  logic [$clog2(SLOTS):0]     len_i,
  output logic                       sdo_o,
  output logic                       oe_o,
  output logic [W-1:0]               rx_data_o,
  output logic                       rx_valid_o,
  output logic                       err_o,
  input  logic [W-1:0]               tx_data_i,
  input  logic                       tx_valid_i,
  output logic                       tx_ready_o
);
  localparam int SW = $clog2(SLOTS);
  localparam logic [SW-1:0] LAST_SLOT = SW'(SLOTS - 1);
  localparam logic [SW:0]   FULL_CNT  = (SW+1)'(SLOTS);

  logic          active_q;
  logic [SW-1:0] slot_q, first_q;
  logic [SW:0]   len_q, rxcnt_q;
  logic [W-1:0]  txw_q, hold_q, rxsh_q, rx_data_q;
  logic          hold_full_q, sdo_q, rx_valid_q, err_q;

  logic          start, close, advance, accept, in_code, last_bit;
  logic [W-1:0]  next_word;
  logic [SW:0]   slot_x, end_x;

  // bit of word w carried by slot s for a code at f of length l, else 0
  function automatic logic pick(logic [W-1:0] w, logic [SW-1:0] f,
                                logic [SW:0] l, logic [SW:0] s);
    logic [SW:0] off, idx;
    pick = 1'b0;
    if (s >= {1'b0, f} && s < {1'b0, f} + l) begin
      off = s - {1'b0, f};
      idx = l - 1'b1 - off;
      for (int i = 0; i < W; i++)
        if (idx == (SW+1)'(i)) pick = w[i];
    end
  endfunction

  assign start     = rise_i && stb_i && (!active_q || slot_q == LAST_SLOT);
  assign close     = rise_i && active_q && !stb_i;
  assign advance   = rise_i && active_q && stb_i && !start;
  assign accept    = tx_valid_i && !hold_full_q;
  assign next_word = hold_full_q ? hold_q : '0;
  assign slot_x    = {1'b0, slot_q};
  assign end_x     = {1'b0, first_q} + len_q;
  assign in_code   = slot_x >= {1'b0, first_q} && slot_x < end_x;
  assign last_bit  = slot_x == end_x - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q    <= 1'b0;
      slot_q      <= '0;
      first_q     <= '0;
      len_q       <= '0;
      txw_q       <= '0;
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      rxsh_q      <= '0;
      rxcnt_q     <= '0;
      rx_data_q   <= '0;
      rx_valid_q  <= 1'b0;
      err_q       <= 1'b0;
      sdo_q       <= 1'b0;
    end else begin
      rx_valid_q <= 1'b0;
      err_q      <= 1'b0;
      if (start) begin
        active_q    <= 1'b1;
        slot_q      <= '0;
        first_q     <= first_i;
        len_q       <= len_i;
        txw_q       <= next_word;
        hold_full_q <= 1'b0;
        rxsh_q      <= '0;
        rxcnt_q     <= '0;
        sdo_q       <= pick(next_word, first_i, len_i, '0);
        err_q       <= active_q && (rxcnt_q != FULL_CNT);
      end else if (close) begin
        active_q <= 1'b0;
        sdo_q    <= 1'b0;
        err_q    <= (rxcnt_q != FULL_CNT);
      end else if (advance) begin
        slot_q <= slot_q + 1'b1;
        sdo_q  <= pick(txw_q, first_q, len_q, slot_x + 1'b1);
      end
      if (fall_i && active_q) begin
        if (rxcnt_q != FULL_CNT) rxcnt_q <= rxcnt_q + 1'b1;
        if (in_code) rxsh_q <= {rxsh_q[W-2:0], sdi_i};
        if (in_code && last_bit) begin
          rx_data_q  <= {rxsh_q[W-2:0], sdi_i};
          rx_valid_q <= 1'b1;
        end
      end
      if (accept) begin
        hold_q      <= tx_data_i;
        hold_full_q <= 1'b1;
      end
    end
  end

  assign sdo_o      = sdo_q;
  assign oe_o       = active_q;
  assign rx_data_o  = rx_data_q;
  assign rx_valid_o = rx_valid_q;
  assign err_o      = err_q;
  assign tx_ready_o = !hold_full_q;

  p_quiet_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_o |-> !sdo_o);
  p_oe_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_o) |-> $past(rise_i));
  p_valid_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);
  p_valid_inside_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> oe_o);
  p_err_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);
  p_hold_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_i && tx_ready_o) |=> !tx_ready_o);
endmodule

// File: rtl/sp_port.sv
module sp_port
  import sp_pkg::*;
#(
  parameter int PCM_W    = 8,
  parameter int ADP_W    = 4,
  parameter int SLOTS    = 8,
  parameter int BUS_HALF = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_mode_i,
  input  logic             bclk_i,
  output logic             bus_bclk_o,
  input  logic             pcm_stb_i,
  input  logic             adp_stb_i,
  input  logic [1:0]       rate_i,
  input  logic             slot_sel_i,
  input  logic             pcm_sdi_i,
  output logic             pcm_sdo_o,
  output logic             pcm_oe_o,
  input  logic             adp_sdi_i,
  output logic             adp_sdo_o,
  output logic             adp_oe_o,
  output logic [PCM_W-1:0] pcm_rx_data_o,
  output logic             pcm_rx_valid_o,
  output logic [ADP_W-1:0] adp_rx_data_o,
  output logic             adp_rx_valid_o,
  input  logic [PCM_W-1:0] pcm_tx_data_i,
  input  logic             pcm_tx_valid_i,
  output logic             pcm_tx_ready_o,
  input  logic [ADP_W-1:0] adp_tx_data_i,
  input  logic             adp_tx_valid_i,
  output logic             adp_tx_ready_o,
  output logic             pcm_err_o,
  output logic             adp_err_o
);
  localparam int SW = $clog2(SLOTS);

  logic [3:0]  sig_sync;
  logic        rise, fall;
  adp_rate_e   rate;
  logic [SW-1:0] adp_first;
  logic [SW:0]   adp_len;

  sp_tick #(.BUS_HALF(BUS_HALF), .NSIG(4)) u_tick (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_mode_i (bus_mode_i),
    .bclk_i     (bclk_i),
    .sig_i      ({adp_sdi_i, pcm_sdi_i, adp_stb_i, pcm_stb_i}),
    .bus_bclk_o (bus_bclk_o),
    .sig_o      (sig_sync),
    .rise_o     (rise),
    .fall_o     (fall)
  );

  assign rate      = adp_rate_e'(rate_i);
  assign adp_first = SW'(code_first(rate, slot_sel_i));
  assign adp_len   = (SW+1)'(code_len(rate));

  sp_lane #(.W(PCM_W), .SLOTS(SLOTS)) u_pcm (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise_i     (rise),
    .fall_i     (fall),
    .stb_i      (sig_sync[0]),
    .sdi_i      (sig_sync[2]),
    .first_i    ('0),
    .len_i      ((SW+1)'(PCM_W)),
    .sdo_o      (pcm_sdo_o),
    .oe_o       (pcm_oe_o),
    .rx_data_o  (pcm_rx_data_o),
    .rx_valid_o (pcm_rx_valid_o),
    .err_o      (pcm_err_o),
    .tx_data_i  (pcm_tx_data_i),
    .tx_valid_i (pcm_tx_valid_i),
    .tx_ready_o (pcm_tx_ready_o)
  );

  sp_lane #(.W(ADP_W), .SLOTS(SLOTS)) u_adp (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise_i     (rise),
    .fall_i     (fall),
    .stb_i      (sig_sync[1]),
    .sdi_i      (sig_sync[3]),
    .first_i    (adp_first),
    .len_i      (adp_len),
    .sdo_o      (adp_sdo_o),
    .oe_o       (adp_oe_o),
    .rx_data_o  (adp_rx_data_o),
    .rx_valid_o (adp_rx_valid_o),
    .err_o      (adp_err_o),
    .tx_data_i  (adp_tx_data_i),
    .tx_valid_i (adp_tx_valid_i),
    .tx_ready_o (adp_tx_ready_o)
  );

  p_code_fits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    adp_rx_valid_o |-> (adp_rx_data_o >> adp_len) == '0);
endmodule

// File: tb/sp_port_tb.sv
module sp_port_tb;
  localparam int HALF     = 8;
  localparam int BUS_HALF = 12;

  logic clk = 0, rst_n = 0;
  logic bus_mode = 0, bclk = 0, pcm_stb = 0, adp_stb = 0, slot_sel = 0;
  logic [1:0] rate = 0;
  logic pcm_sdi = 0, adp_sdi = 0;
  logic bus_bclk, pcm_sdo, pcm_oe, adp_sdo, adp_oe;
  logic [7:0] pcm_rx_data; logic pcm_rx_valid;
  logic [3:0] adp_rx_data; logic adp_rx_valid;
  logic [7:0] pcm_tx_data = 0; logic pcm_tx_valid = 0, pcm_tx_ready;
  logic [3:0] adp_tx_data = 0; logic adp_tx_valid = 0, adp_tx_ready;
  logic pcm_err, adp_err;

  int tests = 0, fails = 0;
  int pcm_vcnt = 0, adp_vcnt = 0, pcm_ecnt = 0, adp_ecnt = 0;
  logic [7:0] pcm_last = 0; logic [3:0] adp_last = 0;

  always #10 clk = ~clk;

  sp_port #(.BUS_HALF(BUS_HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_mode_i(bus_mode), .bclk_i(bclk),
    .bus_bclk_o(bus_bclk), .pcm_stb_i(pcm_stb), .adp_stb_i(adp_stb),
    .rate_i(rate), .slot_sel_i(slot_sel), .pcm_sdi_i(pcm_sdi),
    .pcm_sdo_o(pcm_sdo), .pcm_oe_o(pcm_oe), .adp_sdi_i(adp_sdi),
    .adp_sdo_o(adp_sdo), .adp_oe_o(adp_oe), .pcm_rx_data_o(pcm_rx_data),
    .pcm_rx_valid_o(pcm_rx_valid), .adp_rx_data_o(adp_rx_data),
    .adp_rx_valid_o(adp_rx_valid), .pcm_tx_data_i(pcm_tx_data),
    .pcm_tx_valid_i(pcm_tx_valid), .pcm_tx_ready_o(pcm_tx_ready),
    .adp_tx_data_i(adp_tx_data), .adp_tx_valid_i(adp_tx_valid),
    .adp_tx_ready_o(adp_tx_ready), .pcm_err_o(pcm_err), .adp_err_o(adp_err)
  );

  always @(negedge clk) if (rst_n) begin
    if (pcm_rx_valid) begin pcm_vcnt++; pcm_last = pcm_rx_data; end
    if (adp_rx_valid) begin adp_vcnt++; adp_last = adp_rx_data; end
    if (pcm_err) pcm_ecnt++;
    if (adp_err) adp_ecnt++;
  end

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int clen(logic [1:0] r);
    return (r == 2'd1) ? 3 : (r == 2'd2) ? 2 : 4;
  endfunction
  function automatic int cfirst(logic [1:0] r, logic s);
    return (r == 2'd2 && s) ? 2 : 0;
  endfunction
  // expected code output bit in slot k
  function automatic logic exp_code_bit(logic [3:0] w, logic [1:0] r, logic s, int k);
    int f = cfirst(r, s), l = clen(r);
    if (k >= f && k < f + l) return w[l - 1 - (k - f)];
    return 1'b0;
  endfunction
  // expected received code from the eight input slot bits (slot k = bits[7-k])
  function automatic logic [3:0] exp_code_rx(logic [7:0] bits, logic [1:0] r, logic s);
    logic [3:0] v = 0;
    int f = cfirst(r, s), l = clen(r);
    for (int k = f; k < f + l; k++) v = {v[2:0], bits[7-k]};
    return v;
  endfunction

  task automatic push_pcm(logic [7:0] w);
    @(negedge clk); pcm_tx_data = w; pcm_tx_valid = 1;
    @(negedge clk); pcm_tx_valid = 0;
  endtask
  task automatic push_adp(logic [3:0] w);
    @(negedge clk); adp_tx_data = w; adp_tx_valid = 1;
    @(negedge clk); adp_tx_valid = 0;
  endtask

  task automatic run_frame(input int plen, input int alen, input logic [7:0] pin,
                           input logic [7:0] ain, output logic [7:0] pout,
                           output logic [7:0] aout, output logic [9:0] poe,
                           output logic [9:0] aoe);
    pout = 0; aout = 0; poe = 0; aoe = 0;
    for (int k = 0; k < 10; k++) begin
      if (bus_mode) begin @(posedge bus_bclk); @(negedge clk); end
      else begin @(negedge clk); bclk = 1; end
      pcm_stb = (k < plen); adp_stb = (k < alen);
      pcm_sdi = (k < 8) ? pin[7-k] : 1'b0;
      adp_sdi = (k < 8) ? ain[7-k] : 1'b0;
      if (bus_mode) begin bclk = 1'($urandom); @(negedge bus_bclk); @(negedge clk); end
      else repeat (HALF - 1) @(negedge clk);
      if (k < 8) begin pout[7-k] = pcm_sdo; aout[7-k] = adp_sdo; end
      poe[k] = pcm_oe; aoe[k] = adp_oe;
      if (pcm_oe === 1'b0 && pcm_sdo !== 1'b0) chk("R3", "pcm sdo idle", pcm_sdo, 0);
      if (adp_oe === 1'b0 && adp_sdo !== 1'b0) chk("R3", "adp sdo idle", adp_sdo, 0);
      if (!bus_mode) begin @(negedge clk); bclk = 0; repeat (HALF - 1) @(negedge clk); end
    end
  endtask

  // full frame with transmit words, checking every port against the requirements
  task automatic frame_check(string tag, int plen, int alen, logic [7:0] pin,
                             logic [7:0] ain, bit give_p, logic [7:0] wp,
                             bit give_a, logic [3:0] wa);
    logic [7:0] pout, aout, exp_a; logic [9:0] poe, aoe;
    int pv0, av0, pe0, ae0, f, l;
    if (give_p) push_pcm(wp);
    if (give_a) push_adp(wa);
    if (give_p) chk("R7", {tag, " pcm ready low while held"}, pcm_tx_ready, 0);
    pv0 = pcm_vcnt; av0 = adp_vcnt; pe0 = pcm_ecnt; ae0 = adp_ecnt;
    run_frame(plen, alen, pin, ain, pout, aout, poe, aoe);
    f = cfirst(rate, slot_sel); l = clen(rate);
    chk("R3", {tag, " pcm oe window"}, poe, (10'h3FF >> (10 - plen)) & 10'h3FF);
    chk("R3", {tag, " adp oe window"}, aoe, (10'h3FF >> (10 - alen)) & 10'h3FF);
    if (plen == 8) chk("R2 R7", {tag, " pcm tx"}, pout, give_p ? wp : 8'h00);
    exp_a = 0;
    for (int k = 0; k < 8; k++) exp_a[7-k] = (k < alen) ? exp_code_bit(give_a ? wa : 4'h0, rate, slot_sel, k) : 1'b0;
    chk(rate == 2 ? "R4 R5" : "R4", {tag, " adp tx"}, aout, exp_a);
    if (plen >= 8) begin
      chk("R1", {tag, " pcm rx count"}, pcm_vcnt - pv0, 1);
      chk("R1", {tag, " pcm rx word"}, pcm_last, pin);
    end else chk("R6", {tag, " pcm short no valid"}, pcm_vcnt - pv0, 0);
    chk("R6", {tag, " pcm err"}, pcm_ecnt - pe0, plen < 8 ? 1 : 0);
    chk("R6", {tag, " adp err"}, adp_ecnt - ae0, alen < 8 ? 1 : 0);
    if (alen >= f + l) begin
      chk(rate == 2 ? "R4 R5" : "R4", {tag, " adp rx count"}, adp_vcnt - av0, 1);
      chk(rate == 2 ? "R4 R5" : "R4", {tag, " adp rx code"}, adp_last, exp_code_rx(ain, rate, slot_sel));
    end else chk("R6", {tag, " adp short no valid"}, adp_vcnt - av0, 0);
    chk("R7", {tag, " pcm ready after window"}, pcm_tx_ready, 1);
    chk("R7", {tag, " adp ready after window"}, adp_tx_ready, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R9 reset state
    chk("R9", "pcm oe", pcm_oe, 0);
    chk("R9", "adp oe", adp_oe, 0);
    chk("R9", "sdo", {pcm_sdo, adp_sdo}, 0);
    chk("R9", "ready", {pcm_tx_ready, adp_tx_ready}, 2'b11);
    chk("R9", "valid err", {pcm_rx_valid, adp_rx_valid, pcm_err, adp_err}, 0);

    // directed: each rate, both positions (R4 R5), idle words (R7)
    rate = 0; slot_sel = 0; frame_check("d32", 8, 8, 8'hA5, 8'hC3, 1, 8'h96, 1, 4'hB);
    rate = 1; slot_sel = 0; frame_check("d24", 8, 8, 8'h3C, 8'hFF, 1, 8'h81, 1, 4'hF);
    rate = 2; slot_sel = 0; frame_check("d16s0", 8, 8, 8'h01, 8'h9F, 1, 8'h7E, 1, 4'h2);
    rate = 2; slot_sel = 1; frame_check("d16s1", 8, 8, 8'h80, 8'h3B, 1, 8'h55, 1, 4'h1);
    rate = 0; slot_sel = 1; frame_check("d32sel", 8, 8, 8'h5A, 8'h6E, 1, 8'hF0, 1, 4'h9);
    rate = 3; slot_sel = 0; frame_check("drsv", 8, 8, 8'hE7, 8'hA4, 1, 8'h0F, 1, 4'h6);
    rate = 0; frame_check("didle", 8, 8, 8'h42, 8'h11, 0, 8'h00, 0, 4'h0);
    // R6 short windows
    rate = 0; frame_check("dshortp", 5, 8, 8'hC9, 8'h50, 1, 8'h33, 1, 4'h7);
    rate = 0; frame_check("dshorta", 8, 2, 8'h6D, 8'hF0, 1, 8'hCC, 1, 4'hA);
    rate = 2; slot_sel = 1; frame_check("dshorta16", 8, 3, 8'h18, 8'hFF, 0, 8'h00, 1, 4'h3);

    // random frames
    for (int i = 0; i < 24; i++) begin
      rate = 2'($urandom % 3); slot_sel = 1'($urandom);
      frame_check("rnd", 8, 8, 8'($urandom), 8'($urandom), ($urandom % 4) != 0,
                  8'($urandom), ($urandom % 4) != 0, 4'($urandom));
    end

    // R8 bus mode: internal bit clock period, bclk_i ignored
    bus_mode = 1;
    begin
      int t0, t1;
      @(posedge bus_bclk); t0 = $time;
      @(posedge bus_bclk); t1 = $time;
      chk("R8", "bus bit period", (t1 - t0) / 20, 2 * BUS_HALF);
    end
    rate = 0; slot_sel = 0; frame_check("bus32", 8, 8, 8'hB4, 8'h5C, 1, 8'h69, 1, 4'hD);
    rate = 2; slot_sel = 1; frame_check("bus16", 8, 8, 8'h2F, 8'hE1, 1, 8'hD2, 1, 4'h2);
    rate = 1; frame_check("busshort", 6, 8, 8'h77, 8'h88, 1, 8'h11, 0, 4'h0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule